// File: doc/BRIEF.md
# Gap-Timed Downlink Bit Decoder

This block recovers data bits from a demodulated field-present signal on a contactless downlink. The reader sends bits by switching its carrier off for short gaps. The meaning of each bit lies only in how long the field stays on between two gaps. Durations are counted in carrier clock periods, which the block receives as a one-cycle enable on its system clock. A long gap opens a frame. Each following field-on interval is classified as a 0 or a 1. A field that stays on with no further gap closes the frame.

The block produces single-cycle pulses: start of frame, a bit strobe with its value, end of frame, and an error. The error fires when an interval or a gap falls outside every allowed window, and the frame is then dropped. The field cannot be paused, so the bit output has no back-pressure. Each bit is valid for exactly one clock, and a consumer must take it in that cycle. Analog gap detection and command parsing sit outside this block.

Top module: `gap_bit_decoder`

## Requirements
- R1: After reset, all pulse outputs are low and the block waits for a start gap. Field-on intervals seen before a start gap produce no bit and no error.
- R2: Outside a frame, a gap of 10 to 50 carrier ticks pulses `sof_o` on the tick where the field returns. Outside a frame, a gap of any other length is ignored.
- R3: Inside a frame, a field-on interval of 16 to 31 ticks pulses `bit_vld_o` with `bit_o` = 0 on the tick where the following gap begins.
- R4: Inside a frame, a field-on interval of 48 to 63 ticks pulses `bit_vld_o` with `bit_o` = 1 on the tick where the following gap begins.
- R5: Bits leave the block in the order in which their intervals arrive on the line.
- R6: Inside a frame, a field-on interval that ends with a gap and lies in neither data window (including exactly 64 ticks) pulses `err_o` and ends the frame. No bits follow until a new start gap.
- R7: Inside a frame, a gap between bits shorter than 8 or longer than 30 ticks pulses `err_o` on the tick where the field returns, and ends the frame.
- R8: Inside a frame, on the 65th consecutive field-on tick, `eof_o` pulses once and the frame ends without an error.
- R9: Interval counters saturate instead of wrapping. A gap of 136 or 138 ticks is never taken for a valid gap of 8 or 10 ticks.
- R10: Only cycles with `fc_en_i` high count toward a duration, and only those cycles can raise an output. The level of `gap_i` during other cycles has no effect.
- R11: `sof_o`, `bit_vld_o`, `eof_o` and `err_o` are one-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en_i | input | 1 | One-cycle enable per carrier period |
| gap_i | input | 1 | 1 while the field is absent (gap), 0 while the field is on |
| bit_vld_o | output | 1 | Bit strobe, one cycle |
| bit_o | output | 1 | Decoded bit value, valid with `bit_vld_o` |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |
| err_o | output | 1 | Frame error pulse |

## Verification
Every decision is taken on an enabled carrier tick that the clock edge samples, and it is registered at that same edge, so each result appears exactly one clock after the deciding tick is driven. A start-of-frame or gap-error result falls on the first field-on tick after a gap. A bit or interval-error result falls on the first gap tick. An end-of-frame result falls on the 65th field-on tick. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs with the event its own model predicts for the tick it drove. Disabled cycles expect no event, so any result that is early, late or spurious fails at the exact cycle where it occurs.

// File: rtl/gapdec_pkg.sv
package gapdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic start;
    logic wgap;
    logic zero;
    logic one;
  } win_hits_t;

endpackage

// File: rtl/gapdec_run_timer.sv
module gapdec_run_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en_i,
  input  logic             gap_i,
  output logic             end_o,
  output logic             same_o,
  output logic             lvl_o,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  // A segment ends on the first enabled tick whose level differs.
  assign end_o  = fc_en_i && (gap_i != lvl_q);
  assign same_o = fc_en_i && (gap_i == lvl_q);
  assign lvl_o  = lvl_q;
  assign len_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (end_o) begin
      lvl_q <= gap_i;
      cnt_q <= CNT_ONE;
    end else if (same_o && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en_i |=> $stable(cnt_q) && $stable(lvl_q)); // R10

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    same_o |=> (cnt_q >= $past(cnt_q)) && (cnt_q != '0)); // R9

endmodule

// File: rtl/gapdec_windows.sv
module gapdec_windows
  import gapdec_pkg::*;
#(
  parameter int          CNT_W     = 7,
  parameter int unsigned START_MIN = 10,
  parameter int unsigned START_MAX = 50,
  parameter int unsigned WGAP_MIN  = 8,
  parameter int unsigned WGAP_MAX  = 30,
  parameter int unsigned ZERO_MIN  = 16,
  parameter int unsigned ZERO_MAX  = 31,
  parameter int unsigned ONE_MIN   = 48,
  parameter int unsigned ONE_MAX   = 63
) (
  input  logic [CNT_W-1:0] len_i,
  output win_hits_t        hits_o
);

  localparam int NWIN = 4;
  localparam int unsigned WIN_LO [NWIN] = '{START_MIN, WGAP_MIN, ZERO_MIN, ONE_MIN};
  localparam int unsigned WIN_HI [NWIN] = '{START_MAX, WGAP_MAX, ZERO_MAX, ONE_MAX};

  logic [31:0]     len_w;
  logic [NWIN-1:0] hit;

  assign len_w = 32'(len_i);

  generate
    for (genvar i = 0; i < NWIN; i++) begin : g_win
      assign hit[i] = (len_w >= WIN_LO[i]) && (len_w <= WIN_HI[i]);
    end
  endgenerate

  always_comb begin
    hits_o.start = hit[0];
    hits_o.wgap  = hit[1];
    hits_o.zero  = hit[2];
    hits_o.one   = hit[3];
  end

  AST_DATA_WINDOWS_APART: assert final (!(hits_o.zero && hits_o.one)); // R3

endmodule

// File: rtl/gapdec_frame_ctl.sv
module gapdec_frame_ctl
  import gapdec_pkg::*;
#(
  parameter int          CNT_W   = 7,
  parameter int unsigned EOF_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_i,
  input  logic             same_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] len_i,
  input  win_hits_t        hits_i,
  output logic             sof_o,
  output logic             bit_vld_o,
  output logic             bit_o,
  output logic             eof_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] EOF_CNT = CNT_W'(EOF_LEN);

  frame_st_e st_q, st_d;
  logic sof_d, vld_d, bit_d, eof_d, err_d;

  always_comb begin
    st_d  = st_q;
    sof_d = 1'b0;
    vld_d = 1'b0;
    bit_d = bit_o;
    eof_d = 1'b0;
    err_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (end_i && lvl_i && hits_i.start) begin
          sof_d = 1'b1;
          st_d  = ST_MARK;
        end
      end
      ST_MARK: begin
        if (end_i) begin
          if (hits_i.zero || hits_i.one) begin
            vld_d = 1'b1;
            bit_d = hits_i.one;
            st_d  = ST_SPACE;
          end else begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end else if (same_i && !lvl_i && (len_i == EOF_CNT)) begin
          eof_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_SPACE: begin
        if (end_i) begin
          if (hits_i.wgap) begin
            st_d = ST_MARK;
          end else begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sof_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
      eof_o     <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      sof_o     <= sof_d;
      bit_vld_o <= vld_d;
      bit_o     <= bit_d;
      eof_o     <= eof_d;
      err_o     <= err_d;
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_o, bit_vld_o, eof_o, err_o})); // R11

  AST_BIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |=> !bit_vld_o); // R11

  AST_SOF_OPENS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (st_q == ST_MARK)); // R2

  AST_BIT_OPENS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> (st_q == ST_SPACE)); // R3

  AST_ERR_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (st_q == ST_IDLE)); // R6

  AST_EOF_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (st_q == ST_IDLE)); // R8

endmodule

// File: rtl/gap_bit_decoder.sv
module gap_bit_decoder
  import gapdec_pkg::*;
#(
  parameter int          CNT_W     = 7,
  parameter int unsigned START_MIN = 10,
  parameter int unsigned START_MAX = 50,
  parameter int unsigned WGAP_MIN  = 8,
  parameter int unsigned WGAP_MAX  = 30,
  parameter int unsigned ZERO_MIN  = 16,
  parameter int unsigned ZERO_MAX  = 31,
  parameter int unsigned ONE_MIN   = 48,
  parameter int unsigned ONE_MAX   = 63,
  parameter int unsigned EOF_LEN   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fc_en_i,
  input  logic gap_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic sof_o,
  output logic eof_o,
  output logic err_o
);

  logic             seg_end;
  logic             seg_same;
  logic             seg_lvl;
  logic [CNT_W-1:0] seg_len;
  win_hits_t        hits;

  gapdec_run_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_en_i (fc_en_i),
    .gap_i   (gap_i),
    .end_o   (seg_end),
    .same_o  (seg_same),
    .lvl_o   (seg_lvl),
    .len_o   (seg_len)
  );

  gapdec_windows #(
    .CNT_W     (CNT_W),
    .START_MIN (START_MIN),
    .START_MAX (START_MAX),
    .WGAP_MIN  (WGAP_MIN),
    .WGAP_MAX  (WGAP_MAX),
    .ZERO_MIN  (ZERO_MIN),
    .ZERO_MAX  (ZERO_MAX),
    .ONE_MIN   (ONE_MIN),
    .ONE_MAX   (ONE_MAX)
  ) u_windows (
    .len_i  (seg_len),
    .hits_o (hits)
  );

  gapdec_frame_ctl #(
    .CNT_W   (CNT_W),
    .EOF_LEN (EOF_LEN)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_i     (seg_end),
    .same_i    (seg_same),
    .lvl_i     (seg_lvl),
    .len_i     (seg_len),
    .hits_i    (hits),
    .sof_o     (sof_o),
    .bit_vld_o (bit_vld_o),
    .bit_o     (bit_o),
    .eof_o     (eof_o),
    .err_o     (err_o)
  );

  AST_EOF_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> !$past(gap_i)); // R8

  AST_RESULT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_o || bit_vld_o || eof_o || err_o) |-> $past(fc_en_i)); // R10

endmodule

// File: tb/gap_bit_decoder_tb_top.sv
module gap_bit_decoder_tb_top;

  localparam int EV_NONE  = 0;
  localparam int EV_SOF   = 1;
  localparam int EV_B0    = 2;
  localparam int EV_B1    = 3;
  localparam int EV_EOF   = 4;
  localparam int EV_ERR   = 5;
  localparam int EV_MULTI = 6;

  localparam int M_IDLE  = 0;
  localparam int M_MARK  = 1;
  localparam int M_SPACE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_en_i = 1'b0;
  logic gap_i = 1'b0;
  logic bit_vld_o, bit_o, sof_o, eof_o, err_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    pend_valid = 1'b0;
  int    pend_ev = EV_NONE;
  string pend_tag = "R1";
  string tag_ovr = "";
  bit    stall_en = 1'b0;
  int    m_st = M_IDLE;
  bit    cur_lvl = 1'b0;
  int    cur_len = 0;
  int    obs_bits[$];

  always #4 clk = ~clk;

  gap_bit_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_en_i   (fc_en_i),
    .gap_i     (gap_i),
    .bit_vld_o (bit_vld_o),
    .bit_o     (bit_o),
    .sof_o     (sof_o),
    .eof_o     (eof_o),
    .err_o     (err_o)
  );

  function automatic int obs_code();
    int n;
    n = int'(sof_o) + int'(bit_vld_o) + int'(eof_o) + int'(err_o);
    if (n > 1) return EV_MULTI;
    if (sof_o) return EV_SOF;
    if (bit_vld_o) return bit_o ? EV_B1 : EV_B0;
    if (eof_o) return EV_EOF;
    if (err_o) return EV_ERR;
    return EV_NONE;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected result of the segment that ends now (bench model of the requirements).
  function automatic void decide(output int ev, output string tag);
    ev = EV_NONE;
    tag = "R1";
    if (cur_lvl) begin
      if (m_st == M_IDLE) begin
        tag = "R2";
        if (cur_len >= 10 && cur_len <= 50) begin
          ev = EV_SOF;
          m_st = M_MARK;
        end
      end else if (m_st == M_SPACE) begin
        tag = "R7";
        if (cur_len >= 8 && cur_len <= 30) begin
          m_st = M_MARK;
        end else begin
          ev = EV_ERR;
          m_st = M_IDLE;
        end
      end
    end else begin
      if (m_st == M_MARK) begin
        if (cur_len >= 16 && cur_len <= 31) begin
          ev = EV_B0; tag = "R3"; m_st = M_SPACE;
        end else if (cur_len >= 48 && cur_len <= 63) begin
          ev = EV_B1; tag = "R4"; m_st = M_SPACE;
        end else begin
          ev = EV_ERR; tag = "R6"; m_st = M_IDLE;
        end
      end
    end
    if (tag_ovr != "") tag = tag_ovr;
  endfunction

  task automatic cyc(input bit lvl, input bit en, input int exp_ev, input string tag);
    int o;
    @(negedge clk);
    if (pend_valid) begin
      o = obs_code();
      check(o == pend_ev, (o == EV_MULTI) ? "R11" : pend_tag, o, pend_ev);
      if (o == EV_B0 || o == EV_B1) obs_bits.push_back((o == EV_B1) ? 1 : 0);
    end
    gap_i = lvl;
    fc_en_i = en;
    pend_ev = exp_ev;
    pend_tag = tag;
    pend_valid = 1'b1;
  endtask

  task automatic fc_tick(input bit lvl);
    int    ev;
    string tag;
    if (stall_en && $urandom_range(0, 3) == 0) begin
      repeat ($urandom_range(1, 2)) cyc(1'($urandom_range(0, 1)), 1'b0, EV_NONE, "R10");
    end
    ev = EV_NONE;
    tag = "R11";
    if (lvl != cur_lvl) begin
      decide(ev, tag);
      cur_lvl = lvl;
      cur_len = 1;
    end else begin
      cur_len++;
      if (!lvl && m_st == M_MARK && cur_len == 65) begin
        ev = EV_EOF;
        tag = "R8";
        m_st = M_IDLE;
      end
    end
    cyc(lvl, 1'b1, ev, tag);
  endtask

  task automatic seg(input bit lvl, input int n);
    repeat (n) fc_tick(lvl);
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] word);
    obs_bits.delete();
    seg(1'b1, $urandom_range(10, 50));
    for (int i = 0; i < nbits; i++) begin
      seg(1'b0, word[i] ? $urandom_range(48, 63) : $urandom_range(16, 31));
      seg(1'b1, $urandom_range(8, 30));
    end
    seg(1'b0, 70);
    cyc(1'b0, 1'b0, EV_NONE, "R10");
    check(obs_bits.size() == nbits, "R5 count", obs_bits.size(), nbits);
    for (int i = 0; i < nbits && i < obs_bits.size(); i++)
      check(obs_bits[i] == int'(word[i]), "R5 order", obs_bits[i], int'(word[i]));
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (4) begin
      @(negedge clk);
      check({sof_o, bit_vld_o, eof_o, err_o} == 4'b0 || rst_n, "R1", 0, 0);
    end
    @(negedge clk);
    check({sof_o, bit_vld_o, eof_o, err_o} == 4'b0, "R1",
          int'({sof_o, bit_vld_o, eof_o, err_o}), 0);
    rst_n = 1'b1;

    // R1: field-on before any start gap gives nothing
    seg(1'b0, 20);
    seg(1'b1, 5);
    seg(1'b0, 20);

    // R2 start window edges, R3/R4 data window edges, R7 gap edges, R8 end
    seg(1'b1, 9);  seg(1'b0, 20);
    seg(1'b1, 51); seg(1'b0, 20);
    seg(1'b1, 10); seg(1'b0, 16);
    seg(1'b1, 8);  seg(1'b0, 31);
    seg(1'b1, 30); seg(1'b0, 48);
    seg(1'b1, 8);  seg(1'b0, 63);
    seg(1'b1, 8);  seg(1'b0, 70);

    // R6 bad intervals, 64 ticks then a gap is an error
    seg(1'b1, 50); seg(1'b0, 15);
    seg(1'b1, 20); seg(1'b0, 32);
    seg(1'b1, 12); seg(1'b0, 47);
    seg(1'b1, 12); seg(1'b0, 64);
    // R7 bad gaps
    seg(1'b1, 12); seg(1'b0, 20);
    seg(1'b1, 7);  seg(1'b0, 20);
    seg(1'b1, 12); seg(1'b0, 20);
    seg(1'b1, 31); seg(1'b0, 70);

    // R9 saturation: lengths that would wrap into valid windows
    tag_ovr = "R9";
    seg(1'b1, 138); seg(1'b0, 20);
    seg(1'b1, 12);  seg(1'b0, 20);
    seg(1'b1, 136); seg(1'b0, 70);
    tag_ovr = "";

    // R10 with stalls and random levels on disabled cycles; R5 order
    stall_en = 1'b1;
    for (int f = 0; f < 30; f++) send_frame($urandom_range(1, 16), $urandom());

    // constrained random segments around the windows
    for (int s = 0; s < 120; s++) begin
      seg(~cur_lvl, $urandom_range(1, 4) == 1 ? $urandom_range(1, 140) : $urandom_range(6, 66));
    end
    seg(1'b0, 70);
    cyc(1'b0, 1'b0, EV_NONE, "R10");
    cyc(1'b0, 1'b0, EV_NONE, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog R11: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule